// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the data accesses of a load/store pipeline for addresses that software wants to trap on. It holds two independent watchpoints. Each one is a base register that names a starting doubleword and a 16-bit control word. The control word gives the length of the watched range as a count of extra doublewords, and it says which accesses may trigger: by privilege, by translation mode and by direction. A control bit can also clear the top address bit for privileged accesses.

The access descriptor is presented as it stands in the second stage of the load/store pipeline. The block compares the access against both ranges in that stage and registers the result. On the next cycle it gives a match flag and a 64-bit syndrome word. That timing lets the flag travel alongside the store data into the data cache, where it makes the access fail as a protection violation would. The syndrome word is meant to be ORed into the interrupt status register when the data storage interrupt is taken.

Software reaches the four registers through a plain register-write port and a combinational register-read port. Both are addressed by a 10-bit special-register number. All ports are plain control and status pins with no handshake. An access is a single-cycle qualifier and a write is a single-cycle strobe, so the block applies no back-pressure.

Top module: `dwatch_unit`

## Requirements
- R1: Register number 180 selects base register 0, 181 selects base register 1, 188 selects control register 0 and 189 selects control register 1. A base register stores write-data bits 63:3 and reads back with bits 2:0 zero. A control register stores write-data bits 15:0 and reads back with bits 63:16 zero. Any other number reads as zero, and a write to it changes no register.
- R2: An access hits watchpoint i when its doubleword address (address bits 63:3) lies between base(i) and base(i) plus control bits 15:10, both ends included. That sum is the upper limit, and the field is an unsigned doubleword count.
- R3: The upper limits are recomputed during the cycle after any write to one of the four registers. An access presented in that cycle never produces a match.
- R4: A non-privileged access can hit only when control bit 0 is set. A privileged access can hit only when control bit 2 is set.
- R5: When control bit 3 is clear, the access's translation mode must equal control bit 4. When bit 3 is set, translation mode does not matter.
- R6: A load can hit only when control bit 5 is set. A store can hit only when control bit 6 is set.
- R7: For a privileged access with control bit 7 set, address bit 63 is treated as zero before the range comparison. For any other access the full address is compared.
- R8: A match needs both access-valid and cache-request to be high. Touch, sync and flush accesses never match.
- R9: The match flag is the OR of both watchpoints. It appears on `match_o` on the cycle after the access is presented and is low otherwise.
- R10: While `match_o` is high, `syndrome_o` has bit 22 set and has bit 25 equal to the store flag of the access. While `match_o` is low, `syndrome_o` is zero.
- R11: Reset clears all base, control and upper-limit registers and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_num | input | 10 | Register number for the write |
| wr_data | input | 64 | Write data |
| rd_num | input | 10 | Register number for the read |
| rd_data | output | 64 | Read data, combinational |
| acc_valid | input | 1 | Access present in stage two |
| acc_cache | input | 1 | Access is a data-cache request |
| acc_addr | input | 64 | Effective byte address |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_priv | input | 1 | Privileged access |
| acc_virt | input | 1 | Translation enabled for the access |
| acc_touch | input | 1 | Cache touch operation |
| acc_sync | input | 1 | Sync operation |
| acc_flush | input | 1 | Cache flush operation |
| match_o | output | 1 | Registered watchpoint match |
| syndrome_o | output | 64 | Status bits for the interrupt status register |

## Verification
The bench builds the block with its default parameters: two watchpoints, 64-bit addresses, doubleword granularity, and a 6-bit length field at control bits 15:10. With these values it can reach both range edges exactly and one doubleword beyond each edge. It also reaches both extremes of the length field (zero, a single doubleword, and 63), and an address with bit 63 set that lands in range only after trimming. The table walks each qualifier bit in both polarities against privileged, translated, load and store accesses. Directed tests cover the suppression cycle after a write, a change of range length, the OR of the two watchpoints, ignored register numbers, and a reset taken in the middle of a run.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

  // control-word bit positions (software encodes these)
  localparam int CB_USER  = 0;
  localparam int CB_PRIV  = 2;
  localparam int CB_ANYX  = 3;
  localparam int CB_XVAL  = 4;
  localparam int CB_LOAD  = 5;
  localparam int CB_STORE = 6;
  localparam int CB_TRIM  = 7;

  // syndrome bit positions decoded by the interrupt status register
  localparam int SYN_WATCH = 22;
  localparam int SYN_STORE = 25;

  // qualifier check on the low byte of a control word
  function automatic logic qual_ok(input logic [7:0] c,
                                   input logic priv,
                                   input logic virt,
                                   input logic store);
    logic ok;
    ok = priv ? c[CB_PRIV] : c[CB_USER];
    if (!c[CB_ANYX] && (virt != c[CB_XVAL])) ok = 1'b0;
    if (store ? !c[CB_STORE] : !c[CB_LOAD]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs #(
  parameter int NUM_WP    = 2,
  parameter int ADDR_W    = 64,
  parameter int GRAN      = 3,
  parameter int CTRL_W    = 16,
  parameter int CNT_LSB   = 10,
  parameter int CNT_W     = 6,
  parameter int SPR_W     = 10,
  parameter int BASE_NUM0 = 180,
  parameter int CTRL_NUM0 = 188,
  localparam int DW_W     = ADDR_W - GRAN
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [SPR_W-1:0]              wr_num,
  input  logic [ADDR_W-1:0]             wr_data,
  input  logic [SPR_W-1:0]              rd_num,
  output logic [ADDR_W-1:0]             rd_data,
  output logic [NUM_WP-1:0][DW_W-1:0]   base_o,
  output logic [NUM_WP-1:0][CTRL_W-1:0] ctrl_o,
  output logic [NUM_WP-1:0][DW_W-1:0]   uplim_o,
  output logic                          pending_o
);

  logic [NUM_WP-1:0] sel_base, sel_ctrl;
  logic              pending_q;

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    assign sel_base[i] = wr_en && (wr_num == SPR_W'(BASE_NUM0 + i));
    assign sel_ctrl[i] = wr_en && (wr_num == SPR_W'(CTRL_NUM0 + i));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[i]  <= '0;
        ctrl_o[i]  <= '0;
        uplim_o[i] <= '0;
      end else begin
        if (sel_base[i]) base_o[i] <= wr_data[ADDR_W-1:GRAN];
        if (sel_ctrl[i]) ctrl_o[i] <= wr_data[CTRL_W-1:0];
        if (pending_q)
          uplim_o[i] <= base_o[i] + DW_W'(ctrl_o[i][CNT_LSB +: CNT_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pending_q <= 1'b0;
    else     pending_q <= |{sel_base, sel_ctrl};
  end
  assign pending_o = pending_q;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WP; i++) begin
      if (rd_num == SPR_W'(BASE_NUM0 + i)) rd_data = {base_o[i], {GRAN{1'b0}}};
      if (rd_num == SPR_W'(CTRL_NUM0 + i)) rd_data = ADDR_W'(ctrl_o[i]);
    end
  end

  // R3: a write to the first base register opens the recompute cycle
  p_pend_after_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_num == SPR_W'(BASE_NUM0)) |=> pending_o);

  // R3: upper limits move only at the end of a recompute cycle
  p_uplim_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !pending_o |=> $stable(uplim_o));

  // R1: base readback has zero low bits
  p_base_rd_low_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_num == SPR_W'(BASE_NUM0)) |-> (rd_data[GRAN-1:0] == '0));

  // R1: control readback is zero above the control width
  p_ctrl_rd_ext_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_num == SPR_W'(CTRL_NUM0)) |-> (rd_data[ADDR_W-1:CTRL_W] == '0));

endmodule

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
  import dwatch_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int GRAN   = 3,
  localparam int DW_W  = ADDR_W - GRAN
) (
  input  logic [DW_W-1:0]   base,
  input  logic [DW_W-1:0]   uplim,
  input  logic [7:0]        ctrl_lo,
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  input  logic              virt,
  input  logic              store,
  output logic              hit
);

  logic [DW_W-1:0] dw;
  logic [DW_W:0]   d_lo, d_hi;
  logic            in_range;

  always_comb begin
    dw = addr[ADDR_W-1:GRAN];
    if (priv && ctrl_lo[CB_TRIM]) dw[DW_W-1] = 1'b0;
    d_lo = {1'b0, dw} - {1'b0, base};
    d_hi = {1'b0, uplim} - {1'b0, dw};
    in_range = !d_lo[DW_W] && !d_hi[DW_W];
    hit = in_range && qual_ok(ctrl_lo, priv, virt, store);
  end

  // R4: a hit always carries the matching privilege enable
  always_comb begin
    if (hit === 1'b1)
      p_hit_priv_r4: assert (priv ? ctrl_lo[CB_PRIV] : ctrl_lo[CB_USER]);
  end

endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter int NUM_WP    = 2,
  parameter int ADDR_W    = 64,
  parameter int GRAN      = 3,
  parameter int CTRL_W    = 16,
  parameter int CNT_LSB   = 10,
  parameter int CNT_W     = 6,
  parameter int SPR_W     = 10,
  parameter int BASE_NUM0 = 180,
  parameter int CTRL_NUM0 = 188,
  parameter int SYN_W     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SPR_W-1:0]  wr_num,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SPR_W-1:0]  rd_num,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              acc_valid,
  input  logic              acc_cache,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic              acc_priv,
  input  logic              acc_virt,
  input  logic              acc_touch,
  input  logic              acc_sync,
  input  logic              acc_flush,
  output logic              match_o,
  output logic [SYN_W-1:0]  syndrome_o
);

  localparam int DW_W = ADDR_W - GRAN;

  logic [NUM_WP-1:0][DW_W-1:0]   base, uplim;
  logic [NUM_WP-1:0][CTRL_W-1:0] ctrl;
  logic                          pending;
  logic [NUM_WP-1:0]             hits;
  logic                          gate, match_d;

  dwatch_regs #(
    .NUM_WP(NUM_WP), .ADDR_W(ADDR_W), .GRAN(GRAN), .CTRL_W(CTRL_W),
    .CNT_LSB(CNT_LSB), .CNT_W(CNT_W), .SPR_W(SPR_W),
    .BASE_NUM0(BASE_NUM0), .CTRL_NUM0(CTRL_NUM0)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .rd_num(rd_num), .rd_data(rd_data), .base_o(base), .ctrl_o(ctrl),
    .uplim_o(uplim), .pending_o(pending)
  );

  for (genvar i = 0; i < NUM_WP; i++) begin : g_cmp
    dwatch_cmp #(.ADDR_W(ADDR_W), .GRAN(GRAN)) u_cmp (
      .base(base[i]), .uplim(uplim[i]), .ctrl_lo(ctrl[i][7:0]),
      .addr(acc_addr), .priv(acc_priv), .virt(acc_virt),
      .store(acc_store), .hit(hits[i])
    );
  end

  assign gate    = acc_valid && acc_cache && !(acc_touch || acc_sync || acc_flush);
  assign match_d = gate && !pending && (|hits);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o    <= 1'b0;
      syndrome_o <= '0;
    end else begin
      match_o    <= match_d;
      syndrome_o <= '0;
      if (match_d) begin
        syndrome_o[SYN_WATCH] <= 1'b1;
        syndrome_o[SYN_STORE] <= acc_store;
      end
    end
  end

  // R3: no match from an access seen in the recompute cycle
  p_no_match_pending_r3: assert property (@(posedge clk) disable iff (rst)
    pending |=> !match_o);

  // R8: ungated accesses never match
  p_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid || !acc_cache || acc_touch || acc_sync || acc_flush) |=> !match_o);

  // R10: syndrome marks every watchpoint match
  p_syn_watch_r10: assert property (@(posedge clk) disable iff (rst)
    match_o |-> syndrome_o[SYN_WATCH]);

  // R10: store bit follows the access direction
  p_syn_store_r10: assert property (@(posedge clk) disable iff (rst)
    match_o |-> (syndrome_o[SYN_STORE] == $past(acc_store)));

  // R10: syndrome is quiet without a match
  p_syn_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !match_o |-> (syndrome_o == '0));

endmodule

// File: tb/dwatch_unit_bench.sv
`timescale 1ns/1ps
module dwatch_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_num = '0;
  logic [63:0] wr_data = '0;
  logic [9:0]  rd_num = '0;
  logic [63:0] rd_data;
  logic        acc_valid = 0, acc_cache = 0, acc_store = 0, acc_priv = 0;
  logic        acc_virt = 0, acc_touch = 0, acc_sync = 0, acc_flush = 0;
  logic [63:0] acc_addr = '0;
  logic        match_o;
  logic [63:0] syndrome_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dwatch_unit u_dwatch_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .rd_num(rd_num), .rd_data(rd_data), .acc_valid(acc_valid),
    .acc_cache(acc_cache), .acc_addr(acc_addr), .acc_store(acc_store),
    .acc_priv(acc_priv), .acc_virt(acc_virt), .acc_touch(acc_touch),
    .acc_sync(acc_sync), .acc_flush(acc_flush), .match_o(match_o),
    .syndrome_o(syndrome_o)
  );

  // vector: {ctrl0[15:0], addr[63:0], flags[7:0], expected match}
  // flags = {store, priv, virt, valid, cache, touch, sync, flush}
  // watchpoint 0 base = byte 0x1000 (doubleword 0x200)
  localparam int NV = 31;
  localparam logic [88:0] VEC [NV] = '{
    {16'h106D, 64'h1000, 8'h18, 1'b1},  // R2 low edge
    {16'h106D, 64'h0FF8, 8'h18, 1'b0},  // R2 one below
    {16'h106D, 64'h1027, 8'h18, 1'b1},  // R2 upper edge
    {16'h106D, 64'h1028, 8'h18, 1'b0},  // R2 one above
    {16'h106D, 64'h1010, 8'h18, 1'b1},  // R2 inside
    {16'h106C, 64'h1000, 8'h18, 1'b0},  // R4 user disabled
    {16'h106C, 64'h1000, 8'h58, 1'b1},  // R4 priv enabled
    {16'h1069, 64'h1000, 8'h58, 1'b0},  // R4 priv disabled
    {16'h1069, 64'h1000, 8'h18, 1'b1},  // R4 user enabled
    {16'h1065, 64'h1000, 8'h18, 1'b1},  // R5 want real, real
    {16'h1065, 64'h1000, 8'h38, 1'b0},  // R5 want real, virt
    {16'h1075, 64'h1000, 8'h38, 1'b1},  // R5 want virt, virt
    {16'h1075, 64'h1000, 8'h18, 1'b0},  // R5 want virt, real
    {16'h106D, 64'h1000, 8'h38, 1'b1},  // R5 mode ignored
    {16'h104D, 64'h1000, 8'h18, 1'b0},  // R6 loads off
    {16'h104D, 64'h1000, 8'h98, 1'b1},  // R6 store on
    {16'h102D, 64'h1000, 8'h98, 1'b0},  // R6 stores off
    {16'h102D, 64'h1000, 8'h18, 1'b1},  // R6 load on
    {16'h106D, 64'h1000, 8'h08, 1'b0},  // R8 not valid
    {16'h106D, 64'h1000, 8'h10, 1'b0},  // R8 not cache
    {16'h106D, 64'h1000, 8'h1C, 1'b0},  // R8 touch
    {16'h106D, 64'h1000, 8'h1A, 1'b0},  // R8 sync
    {16'h106D, 64'h1000, 8'h19, 1'b0},  // R8 flush
    {16'h10ED, 64'h8000000000001000, 8'h58, 1'b1},  // R7 trimmed
    {16'h10ED, 64'h8000000000001000, 8'h18, 1'b0},  // R7 user not trimmed
    {16'h106D, 64'h8000000000001000, 8'h58, 1'b0},  // R7 trim off
    {16'h006D, 64'h1000, 8'h18, 1'b1},  // R2 count 0 hit
    {16'h006D, 64'h1008, 8'h18, 1'b0},  // R2 count 0 above
    {16'hFC6D, 64'h11F8, 8'h18, 1'b1},  // R2 count 63 edge
    {16'hFC6D, 64'h1200, 8'h18, 1'b0},  // R2 count 63 above
    {16'h106D, 64'h1000, 8'hD8, 1'b1}   // R10 privileged store
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_fast(logic [9:0] n, logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_num = n; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr(logic [9:0] n, logic [63:0] d);
    wr_fast(n, d);
    @(negedge clk);  // let the recompute cycle pass
  endtask

  task automatic drive(logic [63:0] a, logic [7:0] f);
    acc_addr = a;
    {acc_store, acc_priv, acc_virt, acc_valid, acc_cache,
     acc_touch, acc_sync, acc_flush} = f;
  endtask

  // present at the current negedge, sample at the next one
  task automatic access(logic [63:0] a, logic [7:0] f, output logic m,
                        output logic [63:0] s);
    drive(a, f);
    @(negedge clk);
    drive(64'h0, 8'h00);
    m = match_o; s = syndrome_o;
  endtask

  function automatic logic [63:0] syn_exp(logic hit, logic st);
    logic [63:0] r;
    r = '0;
    if (hit) begin r[22] = 1'b1; r[25] = st; end
    return r;
  endfunction

  task automatic rd(logic [9:0] n, output logic [63:0] v);
    rd_num = n; #1; v = rd_data;
  endtask

  initial begin
    logic        m;
    logic [63:0] s, v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R11 reset state
    chk("R11 match after reset", 64'(match_o), 64'h0);
    chk("R11 syndrome after reset", syndrome_o, 64'h0);
    rd(10'd180, v); chk("R11 base0 reset", v, 64'h0);
    rd(10'd189, v); chk("R11 ctrl1 reset", v, 64'h0);

    // R1 readback formatting
    wr(10'd180, 64'h1007);
    rd(10'd180, v); chk("R1 base0 readback", v, 64'h1000);
    wr(10'd188, 64'hFFFF_FFFF_FFFF_106D);
    rd(10'd188, v); chk("R1 ctrl0 readback", v, 64'h106D);
    wr(10'd182, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(10'd182, v); chk("R1 unknown number reads zero", v, 64'h0);
    rd(10'd180, v); chk("R1 ignored write kept base0", v, 64'h1000);
    rd(10'd181, v); chk("R1 ignored write kept base1", v, 64'h0);
    @(negedge clk);

    // vector table: R2 R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      wr(10'd188, {48'h0, VEC[k][88:73]});
      access(VEC[k][72:9], VEC[k][8:1], m, s);
      chk($sformatf("R9 table vector %0d match", k), 64'(m), 64'(VEC[k][0]));
      chk($sformatf("R10 table vector %0d syndrome", k), s,
          syn_exp(VEC[k][0], VEC[k][8]));
    end

    // R3 suppression during recompute, then new length takes effect
    wr(10'd188, 64'h106D);
    wr_fast(10'd188, 64'h206D);  // count 8
    access(64'h1000, 8'h18, m, s);
    chk("R3 match suppressed in recompute cycle", 64'(m), 64'h0);
    access(64'h1000, 8'h18, m, s);
    chk("R3 match after recompute", 64'(m), 64'h1);
    access(64'h1040, 8'h18, m, s);
    chk("R3 new upper limit used", 64'(m), 64'h1);
    access(64'h1048, 8'h18, m, s);
    chk("R3 beyond new upper limit", 64'(m), 64'h0);

    // R9 OR of watchpoints
    wr(10'd188, 64'h0);
    wr(10'd181, 64'h5000);
    wr(10'd189, 64'h006D);
    access(64'h5000, 8'h18, m, s);
    chk("R9 watchpoint 1 alone hits", 64'(m), 64'h1);
    access(64'h1000, 8'h18, m, s);
    chk("R9 disabled watchpoint 0 silent", 64'(m), 64'h0);
    wr(10'd188, 64'h106D);
    access(64'h1000, 8'h18, m, s);
    chk("R9 watchpoint 0 with both enabled", 64'(m), 64'h1);
    access(64'h5000, 8'h18, m, s);
    chk("R9 watchpoint 1 with both enabled", 64'(m), 64'h1);

    // R11 reset in mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(10'd181, v); chk("R11 base1 cleared", v, 64'h0);
    rd(10'd188, v); chk("R11 ctrl0 cleared", v, 64'h0);
    access(64'h0, 8'h58, m, s);
    chk("R11 no match after reset", 64'(m), 64'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule